// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block is the target side of a small serial EEPROM on a four-wire SPI link, built as synchronous logic that runs on a local clock. The clock, select and data-in lines pass through synchronisers, and the block finds the clock edges itself. Once select falls, the first byte on the link is an opcode. A read-memory or write-memory opcode is followed by an address and then a stream of data bytes. Status commands move one status byte. Two opcodes arm and disarm a write-enable latch.

The array holds 512 bytes, so an address needs nine bits. In the default variant only one address byte follows the opcode, and opcode bit 3 supplies the ninth address bit. Write data collects in a page buffer. The buffer reaches the array only after select rises at a byte boundary and a busy period of `BUSY_CYCLES` clock cycles has run out. A status read shows this busy period, and the block ignores most commands until it ends.

Top module: `spi_ee_responder`

## Requirements
- R1: After reset, the status byte reads 0x00, every array byte reads 0xFF, and `spi_miso` is 0 whenever the target is deselected.
- R2: Opcodes are matched with bit 3 ignored: 0x01 write status, 0x02 write memory, 0x03 read memory, 0x04 clear latch, 0x05 read status, 0x06 set latch. For memory commands, opcode bit 3 is address bit 8 and the single address byte gives bits 7..0.
- R3: Read status returns {wpen, 0, 0, bp[2:0], latch, busy} (bit 7 down to bit 0) and repeats it for every further byte of the same selection.
- R4: The set-latch command sets status bit 1 and the clear-latch command clears it. Each takes effect when select rises at a byte boundary.
- R5: Write memory and write status leave the array and the status unchanged, and start no busy period, while the latch is clear.
- R6: Read memory returns the byte at the address and then successive bytes, stepping by one and wrapping from 511 to 0.
- R7: Write data fills one 8-byte page. Past the last byte of the page it wraps to the page's first byte, and a later byte replaces an earlier one at the same offset.
- R8: A write that ends at a byte boundary with at least one data byte sets busy (status bit 0) for `BUSY_CYCLES` clock cycles. The array or status update and the clearing of the latch happen when busy ends.
- R9: While busy, every command except read status is ignored, and a memory read during busy returns 0x00.
- R10: If select rises when a byte is only partly shifted in, the command has no effect: no write, no status change, no latch change.
- R11: Write status takes its first data byte and stores only bits 7 and 4..2. Later bytes are ignored.
- R12: SPI mode 0. Input is sampled on the rising edge of `spi_sclk`, output changes after the falling edge, and bytes travel MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; all logic and the busy period run on it |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low target select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 while deselected |

## Verification
First, every location is read in one burst that starts two bytes below the top of the array. This checks the erased contents and shows that the address counter wraps without a gap. A write that starts mid-page and runs ten bytes separates page wrap from linear increment, because the last two bytes overwrite the first two offsets. Reading the neighbouring bytes on each side of that page shows that no write escapes it. The same address sent with and without opcode bit 3 distinguishes the two halves of the array. Sixteen whole pages are then filled with an arithmetic pattern that varies every bit position and read back, which exercises MSB-first shifting on both lines. Status reads taken during busy, after busy, after aborted bytes and after writes without the latch separate the deferred-update, gating and abort rules.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  typedef enum logic [2:0] {
    K_NONE, K_RDSR, K_READ, K_WRITE, K_WRSR, K_WREN, K_WRDI
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_RD, ST_WR, ST_SOUT, ST_SIN, ST_TAIL
  } phase_e;

  // Opcode match; bit 3 is dropped when it carries an address bit.
  function automatic cmd_kind_e decode_opc(input logic [7:0] b, input logic a8_in_op);
    logic [7:0] m;
    m = b;
    if (a8_in_op) m[3] = 1'b0;
    case (m)
      OPC_WRSR:  return K_WRSR;
      OPC_WRITE: return K_WRITE;
      OPC_READ:  return K_READ;
      OPC_WRDI:  return K_WRDI;
      OPC_RDSR:  return K_RDSR;
      OPC_WREN:  return K_WREN;
      default:   return K_NONE;
    endcase
  endfunction

  // Phase that follows an accepted opcode.
  function automatic phase_e phase_after(input cmd_kind_e k);
    case (k)
      K_RDSR:          return ST_SOUT;
      K_READ, K_WRITE: return ST_ADDR;
      K_WRSR:          return ST_SIN;
      default:         return ST_TAIL;
    endcase
  endfunction

  // Status byte layout, bit 7 down to bit 0.
  function automatic logic [7:0] pack_status(input logic wpen, input logic [2:0] bp,
                                             input logic wel, input logic busy);
    return {wpen, 2'b00, bp, wel, busy};
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic ev_sel,
  output logic ev_desel,
  output logic ev_rise,
  output logic ev_fall,
  output logic bit_in
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   sclk_q;
  logic [SYNC_STAGES:0]   cs_q;
  logic [SYNC_STAGES-1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[LAST:0], sclk_i};
      cs_q   <= {cs_q[LAST:0], cs_n_i};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_i};
    end
  end

  logic selected;
  assign selected = !cs_q[LAST];
  assign ev_sel   = !cs_q[LAST] &&  cs_q[SYNC_STAGES];
  assign ev_desel =  cs_q[LAST] && !cs_q[SYNC_STAGES];
  assign ev_rise  = selected &&  sclk_q[LAST] && !sclk_q[SYNC_STAGES];
  assign ev_fall  = selected && !sclk_q[LAST] &&  sclk_q[SYNC_STAGES];
  assign bit_in   = mosi_q[LAST];

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          buf_clr,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] buf_page,
  input  logic                                          buf_wr,
  input  logic [$clog2(PAGE_BYTES)-1:0]                 buf_off,
  input  logic [7:0]                                    buf_data,
  input  logic                                          commit,
  input  logic [$clog2(MEM_BYTES)-1:0]                  rd_addr,
  output logic [7:0]                                    rd_data
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int GW = AW - PW;

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bvalid;
  logic [GW-1:0]         page_q;

  always_ff @(posedge clk) begin
    if (buf_wr) pbuf[buf_off] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= '0;
      page_q <= '0;
    end else if (buf_clr) begin
      bvalid <= '0;
      page_q <= buf_page;
    end else if (buf_wr) begin
      bvalid[buf_off] <= 1'b1;
    end
  end

  // Erased state is all ones; a commit writes only the filled page slots.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (bvalid[i]) mem[{page_q, PW'(i)}] <= pbuf[i];
    end
  end

  assign rd_data = mem[rd_addr];

  // R8: a commit from the controller always finds filled slots in the buffer
  a_r8_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (bvalid != '0));

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES      = 512,
  parameter int PAGE_BYTES     = 8,
  parameter int BUSY_CYCLES    = 1000,
  parameter int ADDR_IN_OPCODE = 1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          ev_sel,
  input  logic                                          ev_desel,
  input  logic                                          ev_rise,
  input  logic                                          ev_fall,
  input  logic                                          bit_in,
  input  logic [7:0]                                    rd_data,
  output logic [$clog2(MEM_BYTES)-1:0]                  rd_addr,
  output logic                                          buf_clr,
  output logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] buf_page,
  output logic                                          buf_wr,
  output logic [$clog2(PAGE_BYTES)-1:0]                 buf_off,
  output logic [7:0]                                    buf_data,
  output logic                                          commit,
  output logic                                          miso
);
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int PW         = $clog2(PAGE_BYTES);
  localparam int ADDR_BYTES = (ADDR_IN_OPCODE != 0) ? 1 : (AW + 7) / 8;
  localparam int ABW        = $clog2(ADDR_BYTES + 1);
  localparam int CW         = $clog2(BUSY_CYCLES + 1);

  // Address stepping rules
  function automatic logic [AW-1:0] step_read(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_write(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + PW'(1)};
  endfunction

  phase_e          phase;
  cmd_kind_e       kind;
  logic [2:0]      bitcnt;
  logic [6:0]      sh_in;
  logic [7:0]      tx_q;
  logic [AW-1:0]   addr_q, rd_ptr, wr_ptr;
  logic [ABW-1:0]  abytes;
  logic            got_data;
  logic [3:0]      sbuf;
  logic            wpen_q, wel_q;
  logic [2:0]      bp_q;
  logic [CW-1:0]   busy_cnt;
  logic            pend_mem, pend_stat;

  // Named internal events
  logic [7:0]    sh_next;
  logic          byte_end, busy, busy_done, clean_end;
  logic          start_wr, start_ws, do_wren, do_wrdi, last_ab;
  cmd_kind_e     opc_kind, kind_acc;
  logic [AW-1:0] addr_seed, addr_shift;
  logic [7:0]    status_val;

  assign sh_next    = {sh_in, bit_in};
  assign byte_end   = ev_rise && (bitcnt == 3'd7);
  assign busy       = (busy_cnt != '0);
  assign busy_done  = (busy_cnt == CW'(1));
  assign clean_end  = ev_desel && (bitcnt == 3'd0);
  assign start_wr   = clean_end && (phase == ST_WR) && got_data;
  assign start_ws   = clean_end && (phase == ST_SIN) && got_data;
  assign do_wren    = clean_end && (phase == ST_TAIL) && (kind == K_WREN);
  assign do_wrdi    = clean_end && (phase == ST_TAIL) && (kind == K_WRDI);
  assign last_ab    = (abytes == ABW'(ADDR_BYTES - 1));
  assign opc_kind   = decode_opc(sh_next, ADDR_IN_OPCODE != 0);
  assign addr_shift = (addr_q << 8) | AW'(sh_next);
  assign status_val = pack_status(wpen_q, bp_q, wel_q, busy);

  generate
    if (ADDR_IN_OPCODE != 0) begin : g_a8_op
      assign addr_seed = AW'(sh_next[3]);
    end else begin : g_a8_bytes
      assign addr_seed = '0;
    end
  endgenerate

  // Opcode acceptance: busy blocks all but status read, latch gates writes
  always_comb begin
    kind_acc = opc_kind;
    case (opc_kind)
      K_READ, K_WREN, K_WRDI: if (busy) kind_acc = K_NONE;
      K_WRITE, K_WRSR:        if (busy || !wel_q) kind_acc = K_NONE;
      default: ;
    endcase
  end

  // Serial sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      kind     <= K_NONE;
      bitcnt   <= '0;
      sh_in    <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      abytes   <= '0;
      got_data <= 1'b0;
      sbuf     <= '0;
    end else if (ev_sel) begin
      phase    <= ST_CMD;
      kind     <= K_NONE;
      bitcnt   <= '0;
      tx_q     <= '0;
      abytes   <= '0;
      got_data <= 1'b0;
    end else if (ev_desel) begin
      phase  <= ST_IDLE;
      bitcnt <= '0;
      tx_q   <= '0;
    end else if (phase != ST_IDLE) begin
      if (ev_rise) begin
        sh_in  <= sh_next[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (byte_end) begin
          case (phase)
            ST_CMD: begin
              kind   <= kind_acc;
              addr_q <= addr_seed;
              phase  <= phase_after(kind_acc);
            end
            ST_ADDR: begin
              addr_q <= addr_shift;
              abytes <= abytes + ABW'(1);
              if (last_ab) begin
                if (kind == K_READ) begin
                  phase  <= ST_RD;
                  rd_ptr <= addr_shift;
                end else begin
                  phase  <= ST_WR;
                  wr_ptr <= addr_shift;
                end
              end
            end
            ST_WR: begin
              wr_ptr   <= step_write(wr_ptr);
              got_data <= 1'b1;
            end
            ST_SIN: begin
              if (!got_data) begin
                sbuf     <= {sh_next[7], sh_next[4:2]};
                got_data <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      if (ev_fall) begin
        if (bitcnt == 3'd0) begin
          case (phase)
            ST_SOUT: tx_q <= status_val;
            ST_RD: begin
              tx_q   <= rd_data;
              rd_ptr <= step_read(rd_ptr);
            end
            default: tx_q <= '0;
          endcase
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  // Status register, latch and busy period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpen_q    <= 1'b0;
      bp_q      <= '0;
      wel_q     <= 1'b0;
      busy_cnt  <= '0;
      pend_mem  <= 1'b0;
      pend_stat <= 1'b0;
    end else begin
      if (start_wr || start_ws) begin
        busy_cnt  <= CW'(BUSY_CYCLES);
        pend_mem  <= start_wr;
        pend_stat <= start_ws;
      end else if (busy) begin
        busy_cnt <= busy_cnt - CW'(1);
      end
      if (do_wren) wel_q <= 1'b1;
      if (do_wrdi) wel_q <= 1'b0;
      if (busy_done) begin
        wel_q     <= 1'b0;
        pend_mem  <= 1'b0;
        pend_stat <= 1'b0;
        if (pend_stat) begin
          wpen_q <= sbuf[3];
          bp_q   <= sbuf[2:0];
        end
      end
    end
  end

  assign rd_addr  = rd_ptr;
  assign buf_clr  = byte_end && (phase == ST_ADDR) && last_ab && (kind == K_WRITE);
  assign buf_page = addr_shift[AW-1:PW];
  assign buf_wr   = byte_end && (phase == ST_WR);
  assign buf_off  = wr_ptr[PW-1:0];
  assign buf_data = sh_next;
  assign commit   = busy_done && pend_mem;
  assign miso     = tx_q[7];

  // R8: the busy period counts down one step per clock
  a_r8_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy_cnt == $past(busy_cnt) - CW'(1)));

  // R8: the latch is clear once the busy period has ended
  a_r8_wel_clear_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel_q);

  // R5: a busy period only starts while the latch was set
  a_r5_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel_q));

  // R4: the latch only rises at a clean deselect
  a_r4_wel_set_on_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(clean_end));

  // R10: a deselect inside a byte leaves latch and busy untouched
  a_r10_abort_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_desel && (bitcnt != 3'd0) && !busy) |=> (!busy && $stable(wel_q)));

  // R9: a memory read never enters its data phase from a busy state
  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RD && $past(phase) == ST_ADDR) |-> !$past(busy));

  // R12: the output byte moves only on a falling clock or a select change
  a_r12_tx_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fall && !ev_sel && !ev_desel) |=> $stable(tx_q));

endmodule

// File: rtl/spi_ee_responder.sv
module spi_ee_responder #(
  parameter int MEM_BYTES      = 512,
  parameter int PAGE_BYTES     = 8,
  parameter int BUSY_CYCLES    = 1000,
  parameter int ADDR_IN_OPCODE = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int GW = AW - PW;

  logic          ev_sel, ev_desel, ev_rise, ev_fall, bit_in;
  logic [7:0]    rd_data, buf_data;
  logic [AW-1:0] rd_addr;
  logic          buf_clr, buf_wr, commit;
  logic [GW-1:0] buf_page;
  logic [PW-1:0] buf_off;

  spi_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .ev_sel(ev_sel), .ev_desel(ev_desel), .ev_rise(ev_rise),
    .ev_fall(ev_fall), .bit_in(bit_in)
  );

  spi_ee_ctrl #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .BUSY_CYCLES(BUSY_CYCLES), .ADDR_IN_OPCODE(ADDR_IN_OPCODE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ev_sel(ev_sel), .ev_desel(ev_desel), .ev_rise(ev_rise),
    .ev_fall(ev_fall), .bit_in(bit_in),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .buf_clr(buf_clr), .buf_page(buf_page), .buf_wr(buf_wr),
    .buf_off(buf_off), .buf_data(buf_data), .commit(commit),
    .miso(spi_miso)
  );

  spi_ee_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) array_i (
    .clk(clk), .rst_n(rst_n),
    .buf_clr(buf_clr), .buf_page(buf_page), .buf_wr(buf_wr),
    .buf_off(buf_off), .buf_data(buf_data), .commit(commit),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: tb/spi_ee_responder_tb_top.sv
module spi_ee_responder_tb_top;
  localparam int HALF = 6;
  localparam int BUSY = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  wire  miso;

  always #5 clk = ~clk;

  spi_ee_responder #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:599];
  logic [7:0] exp_pg [0:7];
  logic [7:0] s;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_n = 1'b1;
    tick(HALF);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      tick(HALF);
      rx[b] = miso;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xbyte(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    sel(); xbyte(8'h05, d); xbyte(8'h00, st); desel();
  endtask

  task automatic read_mem(input int addr, input int n);
    logic [7:0] d;
    logic [8:0] a;
    a = 9'(addr);
    sel();
    xbyte(8'h03 | {4'b0, a[8], 3'b0}, d);
    xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, d);
      rbuf[i] = d;
    end
    desel();
  endtask

  task automatic write_mem(input int addr, input int n);
    logic [7:0] d;
    logic [8:0] a;
    a = 9'(addr);
    sel();
    xbyte(8'h02 | {4'b0, a[8], 3'b0}, d);
    xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
    desel();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset state
    check("R1", "miso idle", {7'b0, miso}, 8'h00);
    rdsr(s);
    check("R1", "status after reset", s, 8'h00);

    // R1 / R6: whole array erased, burst across the top of the array
    read_mem(9'h1FE, 514);
    for (int i = 0; i < 514; i++) check("R1", "erased byte", rbuf[i], 8'hFF);
    check("R1", "miso after deselect", {7'b0, miso}, 8'h00);

    // R5: write without latch is ignored
    wbuf[0] = 8'h11;
    write_mem(9'h040, 1);
    rdsr(s);
    check("R5", "no busy without latch", s, 8'h00);
    read_mem(9'h040, 1);
    check("R5", "array unchanged", rbuf[0], 8'hFF);

    // R4: set and clear latch
    cmd1(8'h06); rdsr(s); check("R4", "latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s); check("R4", "latch cleared", s, 8'h00);
    cmd1(8'h06);

    // R10: clear-latch opcode cut after 5 bits
    sel(); xbits(8'h04, 5, d); desel();
    rdsr(s); check("R10", "partial opcode ignored", s, 8'h02);

    // R10: write cut inside its second data byte
    sel(); xbyte(8'h02, d); xbyte(8'h40, d); xbyte(8'h11, d); xbits(8'h22, 3, d); desel();
    rdsr(s); check("R10", "aborted write: no busy, latch kept", s, 8'h02);
    read_mem(9'h040, 1);
    check("R10", "aborted write: array unchanged", rbuf[0], 8'hFF);

    // R7 / R2: ten bytes from offset 5 of page 0x118 (A8 in opcode bit 3)
    for (int k = 0; k < 10; k++) begin
      wbuf[k] = 8'(8'h40 + k);
      exp_pg[(5 + k) % 8] = 8'(8'h40 + k);
    end
    write_mem(9'h11D, 10);

    // R8 / R3: busy visible, latch still set, status repeats
    sel(); xbyte(8'h05, d); xbyte(8'h00, s);
    check("R8", "busy with latch", s, 8'h03);
    xbyte(8'h00, s);
    check("R3", "status repeats", s, 8'h03);
    desel();

    // R9: read and clear-latch ignored while busy
    read_mem(9'h11D, 1);
    check("R9", "read during busy", rbuf[0], 8'h00);
    cmd1(8'h04);
    rdsr(s); check("R9", "clear-latch ignored while busy", s, 8'h03);

    tick(BUSY + 100);
    rdsr(s); check("R8", "idle and latch cleared after busy", s, 8'h00);

    read_mem(9'h117, 10);
    check("R7", "byte below page", rbuf[0], 8'hFF);
    for (int j = 0; j < 8; j++) check("R7", "page wrap content", rbuf[1 + j], exp_pg[j]);
    check("R7", "byte above page", rbuf[9], 8'hFF);

    // R2: same low address without bit 3 reaches the lower half
    read_mem(9'h01D, 1);
    check("R2", "A8 selects half", rbuf[0], 8'hFF);

    // R6: read wraps from 511 to 0
    cmd1(8'h06); wbuf[0] = 8'h5A; wbuf[1] = 8'hA5; write_mem(9'h1FE, 2); tick(BUSY + 100);
    cmd1(8'h06); wbuf[0] = 8'h3C; write_mem(9'h000, 1); tick(BUSY + 100);
    read_mem(9'h1FE, 3);
    check("R6", "byte 510", rbuf[0], 8'h5A);
    check("R6", "byte 511", rbuf[1], 8'hA5);
    check("R6", "wrap to 0", rbuf[2], 8'h3C);

    // R11: status write fields, first byte only, deferred until busy ends
    cmd1(8'h06);
    sel(); xbyte(8'h01, d); xbyte(8'hFF, d); xbyte(8'h00, d); desel();
    rdsr(s); check("R8", "status update deferred", s, 8'h03);
    tick(BUSY + 100);
    rdsr(s); check("R11", "writable bits only", s, 8'h9C);
    cmd1(8'h06); rdsr(s); check("R11", "latch beside fields", s, 8'h9E);
    cmd1(8'h04);
    sel(); xbyte(8'h01, d); xbyte(8'h00, d); desel();
    rdsr(s); check("R5", "status write without latch", s, 8'h9C);
    cmd1(8'h06);
    sel(); xbyte(8'h01, d); xbyte(8'h00, d); desel();
    tick(BUSY + 100);
    rdsr(s); check("R11", "status cleared", s, 8'h00);

    // R12: sixteen full pages of a pattern touching every bit position
    for (int pg = 0; pg < 16; pg++) begin
      for (int i = 0; i < 8; i++) wbuf[i] = pat(128 + pg * 8 + i);
      cmd1(8'h06);
      write_mem(128 + pg * 8, 8);
      tick(BUSY + 100);
    end
    read_mem(9'h080, 128);
    for (int i = 0; i < 128; i++) check("R12", "pattern readback", rbuf[i], pat(128 + i));
    check("R1", "miso idle at end", {7'b0, miso}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule